// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry with Coarse Fallback

This block keeps the sharer record for a single memory line in a coherence directory. While few processors hold the line, it stores their exact ids in a small set of pointer slots. The storage holds `N_PTRS` pointers of `ceil(lg N_PROCS)` bits each. When a new sharer arrives and every slot is full, the entry switches to an overflow form. With `USE_COARSE=1`, it reuses the same bits as a group vector: each bit marks a group of `ceil(N_PROCS / (ceil(lg N_PROCS)*N_PTRS))` neighbouring processors. With `USE_COARSE=0`, it reports every processor as a possible sharer. Membership answers are conservative. They may name processors that do not hold the line, but they never omit one that does. The entry also keeps one share state common to all holders.

A protocol controller drives the block through a single command port. The commands are clear, add, remove, test, set state, allocate, and start invalidation. The invalidation walker steps through every processor id in ascending order, one id per clock. It marks each id that may hold the line, except the requester. It then pulses a done flag. The default build has 16 processors and 2 pointers. That gives 8 storage bits and groups of 2 processors in coarse form.

Top module: `dir_entry_top`

## Requirements
- R1: After reset or an allocate command (op 6), `state_o` is 0 (invalid) and `mode_o` is 0 (pointer form). A test of any processor returns 0.
- R2: In pointer form, add (op 2) records the processor id in the lowest free slot. Test (op 4) then returns 1 for exactly the recorded ids.
- R3: Adding an id that is already recorded changes nothing. It uses no slot, so a later distinct add still fits without overflow.
- R4: With the coarse variant, an add that finds all slots full and the id absent sets `mode_o` to 1. Bit g of the vector then covers processors g*GROUP to g*GROUP+GROUP-1, with GROUP=2 by default. Every previously recorded sharer and the new one have their group bit set, and later adds set their group bit.
- R5: With the broadcast variant, the same overflow sets `mode_o` to 2. Every processor then tests as a sharer.
- R6: In pointer form, remove (op 3) frees the slot that holds the id. In coarse or broadcast form, remove leaves the entry unchanged.
- R7: Clear (op 1) empties the record and returns `mode_o` to 0. It leaves `state_o` unchanged.
- R8: Set state (op 5) loads `cmd_state_i` into `state_o` on the next clock.
- R9: `hit_o` shows the result of the most recent test command from the clock after that command. It never misses a recorded sharer.
- R10: Start invalidation (op 7, requester id in `cmd_proc_i`) walks ids 0 to N_PROCS-1, one per clock, starting the clock after the command. `inv_valid_o` is high with `inv_id_o` equal to the walk position exactly when that id may share the line and is not the requester. `inv_done_o` pulses for one clock right after the last position.
- R11: While `busy_o` is high, every command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_proc_i | input | ID_W | Processor id operand (requester for invalidation) |
| cmd_state_i | input | 2 | Share state operand |
| busy_o | output | 1 | Invalidation walk in progress |
| hit_o | output | 1 | Result of the last test command |
| state_o | output | 2 | Stored share state |
| mode_o | output | 2 | 0 pointers, 1 coarse vector, 2 broadcast |
| inv_valid_o | output | 1 | Current walk id is an invalidation target |
| inv_id_o | output | ID_W | Current walk id |
| inv_done_o | output | 1 | One-clock pulse after the walk ends |

## Verification
A corrupted slot, valid bit, or group bit shows up on `hit_o` one clock after a test command for the affected processor. It also appears in the next invalidation walk, at the clock slot of that processor id. A wrong form transition appears on `mode_o` on the clock after the add, clear, or remove that caused it. A sweep of test commands over all ids after each step can therefore localise any wrong bit within a few cycles. A walker that is off by one shows as a target, or a done pulse, one position early or late against the cycle-exact expected stream.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLEAR = 3'd1,
    OP_ADD   = 3'd2,
    OP_REM   = 3'd3,
    OP_TEST  = 3'd4,
    OP_SETST = 3'd5,
    OP_ALLOC = 3'd6,
    OP_INVAL = 3'd7
  } dir_op_e;

  typedef enum logic [1:0] {
    MODE_PTR   = 2'd0,
    MODE_CVEC  = 2'd1,
    MODE_BCAST = 2'd2
  } dir_mode_e;

  localparam logic [1:0] ST_INVALID = 2'd0;
endpackage

// File: rtl/dir_member.sv
module dir_member
  import dir_pkg::*;
#(
  parameter int N_PROCS = 16,
  parameter int N_PTRS  = 2,
  parameter int ID_W    = 4,
  parameter int STORE_W = 8,
  parameter int GROUP   = 2
) (
  input  dir_mode_e           mode_i,
  input  logic [N_PTRS-1:0]   ptr_v_i,
  input  logic [STORE_W-1:0]  store_i,
  input  logic [ID_W-1:0]     proc_i,
  output logic                hit_o
);
  logic [N_PTRS-1:0] match;
  logic [ID_W-1:0]   gidx;

  for (genvar k = 0; k < N_PTRS; k++) begin : g_cmp
    assign match[k] = ptr_v_i[k] && (store_i[k*ID_W +: ID_W] == proc_i);
  end

  assign gidx = proc_i / ID_W'(GROUP);

  always_comb begin
    unique case (mode_i)
      MODE_PTR:  hit_o = |match;
      MODE_CVEC: hit_o = store_i[gidx];
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_PROCS    = 16,
  parameter int N_PTRS     = 2,
  parameter int ID_W       = 4,
  parameter int STORE_W    = 8,
  parameter int GROUP      = 2,
  parameter bit USE_COARSE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  dir_op_e            op_i,
  input  logic [ID_W-1:0]    proc_i,
  input  logic [1:0]         state_i,
  output dir_mode_e          mode_o,
  output logic [N_PTRS-1:0]  ptr_v_o,
  output logic [STORE_W-1:0] store_o,
  output logic [1:0]         state_o
);
  dir_mode_e          mode_q, mode_d;
  logic [N_PTRS-1:0]  ptr_v_q, ptr_v_d;
  logic [STORE_W-1:0] store_q, store_d;
  logic [1:0]         state_q, state_d;

  logic [N_PTRS-1:0]  match;
  logic               present, any_free;
  logic [STORE_W-1:0] spill_vec;
  logic [ID_W-1:0]    new_g;

  for (genvar k = 0; k < N_PTRS; k++) begin : g_match
    assign match[k] = ptr_v_q[k] && (store_q[k*ID_W +: ID_W] == proc_i);
  end
  assign present  = |match;
  assign any_free = ~&ptr_v_q;
  assign new_g    = proc_i / ID_W'(GROUP);

  // group vector built from the pointers about to be overwritten
  always_comb begin
    spill_vec = '0;
    for (int k = 0; k < N_PTRS; k++) begin
      spill_vec[store_q[k*ID_W +: ID_W] / ID_W'(GROUP)] = 1'b1;
    end
    spill_vec[new_g] = 1'b1;
  end

  always_comb begin
    mode_d  = mode_q;
    ptr_v_d = ptr_v_q;
    store_d = store_q;
    state_d = state_q;
    if (acc_i) begin
      unique case (op_i)
        OP_CLEAR, OP_ALLOC: begin
          mode_d  = MODE_PTR;
          ptr_v_d = '0;
          store_d = '0;
          if (op_i == OP_ALLOC) state_d = ST_INVALID;
        end
        OP_SETST: state_d = state_i;
        OP_ADD: begin
          if (mode_q == MODE_PTR) begin
            if (!present) begin
              if (any_free) begin
                for (int k = N_PTRS-1; k >= 0; k--) begin
                  if (!ptr_v_q[k]) begin
                    ptr_v_d = ptr_v_q;
                    ptr_v_d[k] = 1'b1;
                    store_d = store_q;
                    store_d[k*ID_W +: ID_W] = proc_i;
                  end
                end
              end else if (USE_COARSE) begin
                mode_d  = MODE_CVEC;
                ptr_v_d = '0;
                store_d = spill_vec;
              end else begin
                mode_d  = MODE_BCAST;
                ptr_v_d = '0;
                store_d = '0;
              end
            end
          end else if (mode_q == MODE_CVEC) begin
            store_d[new_g] = 1'b1;
          end
        end
        OP_REM: begin
          if (mode_q == MODE_PTR) ptr_v_d = ptr_v_q & ~match;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_PTR;
      ptr_v_q <= '0;
      store_q <= '0;
      state_q <= ST_INVALID;
    end else begin
      mode_q  <= mode_d;
      ptr_v_q <= ptr_v_d;
      store_q <= store_d;
      state_q <= state_d;
    end
  end

  assign mode_o  = mode_q;
  assign ptr_v_o = ptr_v_q;
  assign store_o = store_q;
  assign state_o = state_q;

  p_clear_to_ptr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (op_i == OP_CLEAR) |=> (mode_q == MODE_PTR) && (ptr_v_q == '0));

  p_dup_add_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (op_i == OP_ADD) && (mode_q == MODE_PTR) && present
    |=> $stable(ptr_v_q) && $stable(store_q) && (mode_q == MODE_PTR));

  p_overflow_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_PTR) && !(acc_i && (op_i == OP_CLEAR || op_i == OP_ALLOC))
    |=> $stable(mode_q));

  p_rem_overflow_noop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (op_i == OP_REM) && (mode_q != MODE_PTR) |=> $stable(store_q));
endmodule

// File: rtl/dir_inval_seq.sv
module dir_inval_seq #(
  parameter int N_PROCS = 16,
  parameter int ID_W    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] req_i,
  output logic            busy_o,
  output logic [ID_W-1:0] idx_o,
  output logic [ID_W-1:0] req_o,
  output logic            done_o
);
  localparam logic [ID_W-1:0] LAST = ID_W'(N_PROCS - 1);

  logic            busy_q, done_q;
  logic [ID_W-1:0] idx_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      req_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        req_q  <= req_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign req_o  = req_q;
  assign done_o = done_q;

  p_done_ends_walk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && $past(busy_q) && ($past(idx_q) == LAST));

  p_walk_steps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (idx_q != LAST) |=> busy_q && (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/dir_entry_top.sv
module dir_entry_top
  import dir_pkg::*;
#(
  parameter int N_PROCS    = 16,
  parameter int N_PTRS     = 2,
  parameter bit USE_COARSE = 1'b1,
  parameter int ID_W       = $clog2(N_PROCS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [ID_W-1:0] cmd_proc_i,
  input  logic [1:0]      cmd_state_i,
  output logic            busy_o,
  output logic            hit_o,
  output logic [1:0]      state_o,
  output logic [1:0]      mode_o,
  output logic            inv_valid_o,
  output logic [ID_W-1:0] inv_id_o,
  output logic            inv_done_o
);
  localparam int STORE_W = ID_W * N_PTRS;
  localparam int GROUP   = (N_PROCS + STORE_W - 1) / STORE_W;

  dir_op_e            op;
  logic               acc, busy;
  dir_mode_e          mode;
  logic [N_PTRS-1:0]  ptr_v;
  logic [STORE_W-1:0] store;
  logic [ID_W-1:0]    idx, req;
  logic               test_hit, walk_hit, hit_q;

  assign op  = dir_op_e'(cmd_op_i);
  assign acc = cmd_valid_i && !busy;

  dir_store #(
    .N_PROCS(N_PROCS), .N_PTRS(N_PTRS), .ID_W(ID_W),
    .STORE_W(STORE_W), .GROUP(GROUP), .USE_COARSE(USE_COARSE)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .op_i(op),
    .proc_i(cmd_proc_i), .state_i(cmd_state_i),
    .mode_o(mode), .ptr_v_o(ptr_v), .store_o(store), .state_o(state_o)
  );

  dir_member #(
    .N_PROCS(N_PROCS), .N_PTRS(N_PTRS), .ID_W(ID_W),
    .STORE_W(STORE_W), .GROUP(GROUP)
  ) u_test_member (
    .mode_i(mode), .ptr_v_i(ptr_v), .store_i(store),
    .proc_i(cmd_proc_i), .hit_o(test_hit)
  );

  dir_member #(
    .N_PROCS(N_PROCS), .N_PTRS(N_PTRS), .ID_W(ID_W),
    .STORE_W(STORE_W), .GROUP(GROUP)
  ) u_walk_member (
    .mode_i(mode), .ptr_v_i(ptr_v), .store_i(store),
    .proc_i(idx), .hit_o(walk_hit)
  );

  dir_inval_seq #(.N_PROCS(N_PROCS), .ID_W(ID_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(acc && (op == OP_INVAL)), .req_i(cmd_proc_i),
    .busy_o(busy), .idx_o(idx), .req_o(req), .done_o(inv_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hit_q <= 1'b0;
    else if (acc && op == OP_TEST)    hit_q <= test_hit;
  end

  assign busy_o      = busy;
  assign hit_o       = hit_q;
  assign mode_o      = mode;
  assign inv_id_o    = idx;
  assign inv_valid_o = busy && walk_hit && (idx != req);

  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_valid_i |=> $stable(mode) && $stable(ptr_v) && $stable(store) && $stable(state_o));

  p_target_in_walk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> busy_o && !inv_done_o);

  p_setst_loads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (op == OP_SETST) |=> state_o == $past(cmd_state_i));
endmodule

// File: tb/dir_entry_top_tb.sv
module dir_entry_top_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int GRP = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] vld = '0;
  logic [2:0] op = '0;
  logic [3:0] proc = '0;
  logic [1:0] st = '0;

  logic [1:0] busy, hit, ivld, idone;
  logic [1:0] state_a, mode_a, state_b, mode_b;
  logic [3:0] iid_a, iid_b;

  int checks = 0, errors = 0;

  // bench model, index 0 = coarse build, 1 = broadcast build
  int m_mode[2];
  bit m_pv[2][2];
  int m_p[2][2];
  bit [7:0] m_vec[2];
  int m_state[2];

  always #(CLK_P/2) clk = ~clk;

  dir_entry_top #(.N_PROCS(16), .N_PTRS(2), .USE_COARSE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld[0]), .cmd_op_i(op),
    .cmd_proc_i(proc), .cmd_state_i(st), .busy_o(busy[0]), .hit_o(hit[0]),
    .state_o(state_a), .mode_o(mode_a), .inv_valid_o(ivld[0]),
    .inv_id_o(iid_a), .inv_done_o(idone[0]));

  dir_entry_top #(.N_PROCS(16), .N_PTRS(2), .USE_COARSE(1'b0)) u_dut_bc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld[1]), .cmd_op_i(op),
    .cmd_proc_i(proc), .cmd_state_i(st), .busy_o(busy[1]), .hit_o(hit[1]),
    .state_o(state_b), .mode_o(mode_b), .inv_valid_o(ivld[1]),
    .inv_id_o(iid_b), .inv_done_o(idone[1]));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(int s, int p);
    if (m_mode[s] == 0) return (m_pv[s][0] && m_p[s][0] == p) || (m_pv[s][1] && m_p[s][1] == p);
    if (m_mode[s] == 1) return m_vec[s][p/GRP];
    return 1'b1;
  endfunction

  function automatic void model(int s, int o, int p, int sv);
    case (o)
      1, 6: begin
        m_mode[s] = 0; m_pv[s][0] = 0; m_pv[s][1] = 0; m_vec[s] = '0;
        if (o == 6) m_state[s] = 0;
      end
      5: m_state[s] = sv;
      2: begin
        if (m_mode[s] == 0) begin
          if (!exp_hit(s, p)) begin
            if (!m_pv[s][0]) begin m_pv[s][0] = 1; m_p[s][0] = p; end
            else if (!m_pv[s][1]) begin m_pv[s][1] = 1; m_p[s][1] = p; end
            else if (s == 0) begin
              m_mode[s] = 1; m_vec[s] = '0;
              m_vec[s][m_p[s][0]/GRP] = 1; m_vec[s][m_p[s][1]/GRP] = 1; m_vec[s][p/GRP] = 1;
              m_pv[s][0] = 0; m_pv[s][1] = 0;
            end else begin
              m_mode[s] = 2; m_pv[s][0] = 0; m_pv[s][1] = 0;
            end
          end
        end else if (m_mode[s] == 1) m_vec[s][p/GRP] = 1;
      end
      3: if (m_mode[s] == 0) begin
        if (m_pv[s][0] && m_p[s][0] == p) m_pv[s][0] = 0;
        if (m_pv[s][1] && m_p[s][1] == p) m_pv[s][1] = 0;
      end
      default: ;
    endcase
  endfunction

  // drive at negedge, return at the next negedge (one edge applied)
  task automatic cmd(int s, int o, int p, int sv = 0, bit upd = 1);
    @(negedge clk);
    vld = '0; vld[s] = 1'b1; op = 3'(o); proc = 4'(p); st = 2'(sv);
    @(negedge clk);
    vld = '0;
    if (upd) model(s, o, p, sv);
  endtask

  task automatic sweep(int s, string req);
    for (int p = 0; p < N; p++) begin
      cmd(s, 4, p);
      chk($sformatf("%s/R9 test p=%0d", req, p), hit[s], exp_hit(s, p));
    end
  endtask

  task automatic chk_mode(int s, string req);
    chk({req, " mode"}, (s == 0) ? mode_a : mode_b, m_mode[s]);
  endtask

  task automatic walk(int s, int rq, string req);
    cmd(s, 7, rq);
    for (int i = 0; i < N; i++) begin
      bit e;
      e = exp_hit(s, i) && (i != rq);
      chk($sformatf("%s/R10 valid pos=%0d", req, i), ivld[s], e);
      if (e) chk($sformatf("%s/R10 id pos=%0d", req, i), (s == 0) ? iid_a : iid_b, i);
      chk($sformatf("%s/R10 no done pos=%0d", req, i), idone[s], 0);
      if (i == 3) begin
        // R11: add during walk must be dropped
        vld[s] = 1'b1; op = 3'd2; proc = 4'd14;
      end else vld = '0;
      @(negedge clk);
    end
    vld = '0;
    chk({req, "/R10 done"}, idone[s], 1);
    chk({req, "/R10 busy off"}, busy[s], 0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_mode[s] = 0; m_pv[s][0] = 0; m_pv[s][1] = 0; m_vec[s] = '0; m_state[s] = 0;
      m_p[s][0] = 0; m_p[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", state_a, 0);
    chk("R1 reset mode", mode_a, 0);
    chk("R1 reset busy", busy[0], 0);
    sweep(0, "R1");

    cmd(0, 2, 5); cmd(0, 2, 5);
    cmd(0, 2, 9);
    chk_mode(0, "R3");
    sweep(0, "R2");
    walk(0, 5, "R2");
    sweep(0, "R11");

    cmd(0, 3, 5);
    sweep(0, "R6");
    cmd(0, 2, 12);
    chk_mode(0, "R6 reuse");
    cmd(0, 2, 3);
    chk_mode(0, "R4");
    chk("R4 coarse", mode_a, 1);
    sweep(0, "R4");
    cmd(0, 3, 9);
    sweep(0, "R6 coarse");
    cmd(0, 2, 7);
    sweep(0, "R4 add");
    walk(0, 8, "R4");

    cmd(0, 5, 0, 3);
    chk("R8 state", state_a, 3);
    cmd(0, 1, 0);
    chk("R7 mode", mode_a, 0);
    chk("R7 state kept", state_a, 3);
    sweep(0, "R7");
    cmd(0, 2, 15);
    cmd(0, 6, 0);
    chk("R1 alloc state", state_a, 0);
    chk("R1 alloc mode", mode_a, 0);
    sweep(0, "R1 alloc");

    cmd(1, 2, 1); cmd(1, 2, 2);
    chk("R2 bc ptr", mode_b, 0);
    cmd(1, 2, 3);
    chk("R5 bcast", mode_b, 2);
    cmd(1, 3, 1);
    chk("R6 bcast rem", mode_b, 2);
    sweep(1, "R5");
    walk(1, 0, "R5");
    cmd(1, 1, 0);
    chk("R7 bc mode", mode_b, 0);
    sweep(1, "R7 bc");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule